// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

The scheduler asks an SDRAM controller to run a refresh at a fixed interval, and holds off new read and write transfers while that refresh waits. One timer serves every chip-select bank of the controller. Software programs the interval once, as a cycle count, through a configuration write. After the first nonzero value the interval is frozen until reset, so a later bad write cannot shorten or stretch the refresh schedule.

Once the interval is programmed, a down-counter runs. When it expires, a refresh becomes pending. A pending refresh blocks new transfers at once. The refresh request itself only goes out while no transfer is in flight, so a running burst always finishes first. The controller acknowledges a finished refresh with a one-cycle done pulse. That pulse clears the pending state and restarts the interval. If the interval runs out again before the previous refresh was acknowledged, a sticky error flag is set. An enable bit routes this flag to an interrupt, and a write-one clear bit resets it.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset, refresh_req, xfer_hold, err_flag and err_irq are all low, and the timer stays idle until a nonzero interval is written.
- R2: A configuration write with cfg_period equal to 0 leaves the timer idle and does not lock the interval, so a later nonzero write is still accepted.
- R3: The first configuration write with a nonzero cfg_period locks the interval. xfer_hold first rises on the clock edge P+1 cycles after that write's edge. Later cfg_period values are ignored until reset.
- R4: A nonzero cfg_period below MIN_PERIOD (default 41) is taken as MIN_PERIOD.
- R5: While a refresh is pending, xfer_hold is high. refresh_req equals the pending state gated by xfer_busy being low, so a transfer in progress finishes before the refresh is requested.
- R6: A refresh_done pulse while a refresh is pending clears the pending state on the next edge and reloads the counter, so the next request rises P+1 edges after the done edge.
- R7: The counter reloads by itself each time it expires. If it expires while a refresh is still pending, err_flag is set, and it stays set until cleared. The pending refresh remains.
- R8: A configuration write with cfg_err_clr equal to 1 clears err_flag. With cfg_err_clr equal to 0 the write leaves the flag unchanged. A new error in the same cycle takes priority over the clear.
- R9: err_irq equals err_flag AND the interrupt enable. The enable is loaded from cfg_irq_en on every configuration write, whether or not the interval is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_period | input | CNT_W | Refresh interval P in cycles |
| cfg_irq_en | input | 1 | Error interrupt enable value |
| cfg_err_clr | input | 1 | Write 1 to clear the error flag |
| xfer_busy | input | 1 | A read or write transfer is in progress |
| refresh_done | input | 1 | Controller finished the requested refresh |
| refresh_req | output | 1 | Refresh request to the command sequencer |
| xfer_hold | output | 1 | Do not grant new transfers |
| err_flag | output | 1 | Sticky refresh-overrun error |
| err_irq | output | 1 | Error interrupt |

## Verification
The properties assume the controller raises refresh_done only while xfer_hold is high, and only for a single cycle per refresh. The stimulus pulses done only after it has observed a pending refresh. It keeps xfer_busy high across several cycles of a pending refresh to show the deferral. It also lets an interval lapse with no acknowledge to provoke the overrun error. Every configuration write is a single-cycle strobe driven between clock edges.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

   // Raise a nonzero interval to the legal minimum; zero passes through.
   function automatic logic [31:0] clamp_period(input logic [31:0] val,
                                                input logic [31:0] min_val);
      if (val == 32'd0)      return 32'd0;
      else if (val < min_val) return min_val;
      else                    return val;
   endfunction

endpackage

// File: rtl/refresh_cfg.sv
module refresh_cfg #(
   parameter int CNT_W      = 13,
   parameter int MIN_PERIOD = 41
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wr_period,
   input  logic             wr_ien,
   output logic [CNT_W-1:0] period,
   output logic             locked,
   output logic             lock_now,
   output logic [CNT_W-1:0] lock_val,
   output logic             ien
);
   import sdram_refresh_pkg::*;

   logic [31:0] clamped;

   always_comb begin
      clamped  = clamp_period(32'(wr_period), 32'(MIN_PERIOD));
      lock_val = clamped[CNT_W-1:0];
      lock_now = wr && !locked && (wr_period != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period <= '0;
         locked <= 1'b0;
         ien    <= 1'b0;
      end else begin
         if (wr) ien <= wr_ien;
         if (lock_now) begin
            period <= lock_val;
            locked <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] start_val,
   input  logic             run,
   input  logic             restart,
   input  logic [CNT_W-1:0] period,
   output logic             expire
);
   logic [CNT_W-1:0] cnt;

   assign expire = run && !restart && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt <= '0;
      else if (start)              cnt <= start_val;
      else if (run) begin
         if (restart || cnt == '0) cnt <= period;
         else                      cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/refresh_arb.sv
module refresh_arb #(
   parameter bit REG_IRQ = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic done_ok,
   input  logic busy,
   input  logic clr,
   input  logic ien,
   output logic pend,
   output logic req,
   output logic err,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         err  <= 1'b0;
      end else begin
         if (done_ok)     pend <= 1'b0;
         else if (expire) pend <= 1'b1;
         if (expire && pend) err <= 1'b1;
         else if (clr)       err <= 1'b0;
      end
   end

   assign req = pend && !busy;

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= err && ien;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = err && ien;
      end
   endgenerate
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
   parameter int CNT_W      = 13,
   parameter int MIN_PERIOD = 41,
   parameter bit REG_IRQ    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CNT_W-1:0] cfg_period,
   input  logic             cfg_irq_en,
   input  logic             cfg_err_clr,
   input  logic             xfer_busy,
   input  logic             refresh_done,
   output logic             refresh_req,
   output logic             xfer_hold,
   output logic             err_flag,
   output logic             err_irq
);
   localparam int MAX_PERIOD = (1 << CNT_W) - 1;

   generate
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_width
         $error("CNT_W out of range");
      end
      if (MIN_PERIOD < 1 || MIN_PERIOD > MAX_PERIOD) begin : g_bad_min
         $error("MIN_PERIOD does not fit CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] period, lock_val;
   logic             locked, lock_now, ien, expire, pend, done_ok;

   assign done_ok = refresh_done && pend;

   refresh_cfg #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_period(cfg_period),
      .wr_ien(cfg_irq_en), .period(period), .locked(locked),
      .lock_now(lock_now), .lock_val(lock_val), .ien(ien));

   refresh_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(lock_now), .start_val(lock_val),
      .run(locked), .restart(done_ok), .period(period), .expire(expire));

   refresh_arb #(.REG_IRQ(REG_IRQ)) u_arb (
      .clk(clk), .rst_n(rst_n), .expire(expire), .done_ok(done_ok),
      .busy(xfer_busy), .clr(cfg_wr && cfg_err_clr), .ien(ien),
      .pend(pend), .req(refresh_req), .err(err_flag), .irq(err_irq));

   assign xfer_hold = pend;
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
   parameter bit REG_IRQ = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic cfg_wr,
   input logic cfg_err_clr,
   input logic xfer_busy,
   input logic refresh_done,
   input logic refresh_req,
   input logic xfer_hold,
   input logic err_flag,
   input logic err_irq
);
   // R5
   req_implies_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req |-> xfer_hold);
   // R5
   req_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_req |-> !xfer_busy);
   // R6
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_done && xfer_hold) |=> !xfer_hold);
   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !(cfg_wr && cfg_err_clr)) |=> err_flag);
   // R7
   err_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(xfer_hold));
   // R8
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_err_clr && !xfer_hold) |=> !err_flag);

   generate
      if (!REG_IRQ) begin : g_irq_chk
         // R9
         irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
            err_irq |-> err_flag);
      end
   endgenerate
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(.REG_IRQ(REG_IRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_err_clr(cfg_err_clr),
   .xfer_busy(xfer_busy), .refresh_done(refresh_done),
   .refresh_req(refresh_req), .xfer_hold(xfer_hold),
   .err_flag(err_flag), .err_irq(err_irq));

// File: tb/sdram_refresh_sched_test.sv
module sdram_refresh_sched_test;
   localparam int W    = 13;
   localparam int MINP = 41;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0, cfg_irq_en = 1'b0, cfg_err_clr = 1'b0;
   logic [W-1:0] cfg_period = '0;
   logic xfer_busy = 1'b0, refresh_done = 1'b0;
   logic refresh_req, xfer_hold, err_flag, err_irq;

   int n_run = 0, n_fail = 0;

   // behavioural reference state
   int m_cnt = 0, m_period = 0;
   bit m_locked = 0, m_pend = 0, m_err = 0, m_ien = 0;
   bit seen_hold = 0;

   always #5 clk = ~clk;

   sdram_refresh_sched uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_period(cfg_period),
      .cfg_irq_en(cfg_irq_en), .cfg_err_clr(cfg_err_clr),
      .xfer_busy(xfer_busy), .refresh_done(refresh_done),
      .refresh_req(refresh_req), .xfer_hold(xfer_hold),
      .err_flag(err_flag), .err_irq(err_irq));

   task automatic check(input string tag, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_int(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Called at a falling edge with inputs set: compare, clock, update model.
   task automatic tick();
      bit expire, done_ok, lock_now;
      int val;
      #1;
      check("R5 refresh_req", refresh_req, m_pend && !xfer_busy);
      check("R5 xfer_hold", xfer_hold, m_pend);
      check("R7 err_flag", err_flag, m_err);
      check("R9 err_irq", err_irq, m_err && m_ien);
      seen_hold = xfer_hold;
      @(posedge clk);
      if (!rst_n) begin
         m_cnt = 0; m_period = 0; m_locked = 0;
         m_pend = 0; m_err = 0; m_ien = 0;
      end else begin
         val      = int'(cfg_period);
         lock_now = cfg_wr && !m_locked && val != 0;
         done_ok  = refresh_done && m_pend;
         expire   = m_locked && !done_ok && m_cnt == 0;
         if (expire && m_pend) m_err = 1;
         else if (cfg_wr && cfg_err_clr) m_err = 0;
         if (done_ok) m_pend = 0;
         else if (expire) m_pend = 1;
         if (lock_now) begin
            m_period = (val < MINP) ? MINP : val;
            m_cnt    = m_period;
            m_locked = 1;
         end else if (m_locked) begin
            if (done_ok || m_cnt == 0) m_cnt = m_period;
            else m_cnt = m_cnt - 1;
         end
         if (cfg_wr) m_ien = cfg_irq_en;
      end
      @(negedge clk);
      cfg_wr = 0; cfg_err_clr = 0; refresh_done = 0;
   endtask

   task automatic cfg_write(input int p, input bit ien, input bit clr);
      cfg_wr = 1; cfg_period = W'(p); cfg_irq_en = ien; cfg_err_clr = clr;
      tick();
   endtask

   task automatic ticks_to_hold(output int n);
      n = 0;
      for (int i = 0; i < 5000; i++) begin
         tick();
         n++;
         if (seen_hold) break;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int n;
      @(negedge clk);
      tick(); tick();
      rst_n = 1;
      // R1: outputs idle after reset
      tick();
      check("R1 idle hold", xfer_hold, 1'b0);
      check("R1 idle err", err_flag, 1'b0);

      // R2: zero interval keeps timer idle and unlocked
      cfg_write(0, 1, 0);
      repeat (100) tick();
      check("R2 no refresh with zero interval", seen_hold, 1'b0);

      // R3: first nonzero write locks, request after P+1 edges
      cfg_write(50, 1, 0);
      tick();
      cfg_write(60, 1, 0);           // ignored: locked
      ticks_to_hold(n);
      check_int("R3 first request delay", n + 2, 50 + 2);

      // R5: in-flight transfer defers the request
      xfer_busy = 1;
      repeat (5) tick();
      check("R5 hold while busy", xfer_hold, 1'b1);
      check("R5 req suppressed while busy", refresh_req, 1'b0);
      xfer_busy = 0;
      tick();
      check("R5 req after transfer", refresh_req, 1'b1);

      // R6: done releases hold and restarts interval
      refresh_done = 1;
      tick();
      ticks_to_hold(n);
      check_int("R6 interval after done", n, 50 + 2);

      // R7: no acknowledge -> overrun error, pending stays
      repeat (60) tick();
      check("R7 error set", err_flag, 1'b1);
      check("R7 still pending", xfer_hold, 1'b1);
      check("R9 irq enabled", err_irq, 1'b1);

      // R8: write without clear bit keeps the flag
      cfg_write(0, 1, 0);
      tick();
      check("R8 clr=0 no effect", err_flag, 1'b1);
      // R9: disabling the enable masks the interrupt only
      cfg_write(0, 0, 0);
      tick();
      check("R9 irq masked", err_irq, 1'b0);
      check("R9 flag kept", err_flag, 1'b1);
      // R8: clear
      cfg_write(0, 1, 1);
      tick();
      check("R8 cleared", err_flag, 1'b0);
      refresh_done = 1;
      tick();
      repeat (20) tick();

      // R4: small interval raised to the minimum
      rst_n = 0; tick(); tick(); rst_n = 1; tick();
      cfg_write(5, 0, 0);
      ticks_to_hold(n);
      check_int("R4 clamped interval", n, MINP + 2);
      refresh_done = 1;
      tick();
      repeat (10) tick();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule